// File: doc/BRIEF.md
# SD Data Line Error Detector

This block watches one SD data line (DAT0) from the host side and records three kinds of transfer fault in sticky flags: timeouts, CRC faults and end-bit faults. A transfer controller tells it which phase comes next with a one-cycle strobe. The phase can be a read data block, the card's CRC status token after a write, or a busy wait after a response with busy. The block then follows the line bit by bit, once for each SD clock enable pulse. It checks the CRC16 and end bit of read blocks. It checks the 3-bit status token and its end bit. It times the waits for a start bit and for the end of busy against a programmable count.

Strobes are taken only while the block is idle. If more than one strobe arrives in the same cycle, a read takes precedence over a CRC status token, and a CRC status token takes precedence over a busy wait. A CRC status token always leads straight into a busy wait. Software clears each flag by writing 1 to its bit.

Top module: `sd_dat_err_mon`

## Requirements
- R1: After `rd_exp_i`, the block waits for a start bit of 0. It then takes `blk_len_i`*8 data bits, 16 CRC bits (MSB first) and one end bit, each sampled on a cycle with `sd_en_i` high.
- R2: The CRC16 uses polynomial x^16+x^12+x^5+1 (0x1021), starts from zero and covers only the data bits. A mismatch with the received CRC sets `err_crc_o` on the end-bit sample.
- R3: A read end bit sampled as 0 sets `err_end_o`.
- R4: After `cs_exp_i`, the block waits for a start bit of 0, then takes 3 status bits (first bit is the MSB) and an end bit. Any token other than 3'b010 sets `err_crc_o`.
- R5: A CRC status end bit sampled as 0 sets `err_end_o`.
- R6: If no read start bit arrives within the timeout count, `err_tmo_o` is set and the read phase is abandoned.
- R7: If no CRC status start bit arrives within the timeout count, `err_tmo_o` is set.
- R8: Busy means DAT0 is low, and it ends on the first sample of 1. A busy wait begins after every CRC status token, or on `busy_exp_i`. If busy lasts past the timeout count, `err_tmo_o` is set.
- R9: Each wait reloads `tmo_cnt_i` on entry. It fires on the Nth consecutive sample without its event (a count of 0 behaves as 1). An event on that same sample wins over the timeout.
- R10: The flags are sticky. A cycle with `clr_we_i` high clears each flag whose `clr_i` bit is 1 (bit 0 timeout, bit 1 CRC, bit 2 end bit). Bits written as 0 have no effect.
- R11: A set and a clear of the same flag in the same cycle leave the flag set.
- R12: Cycles with `sd_en_i` low neither advance a phase nor count towards a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_en_i | input | 1 | Marks the cycle in which `dat_i` is a valid SD clock sample |
| dat_i | input | 1 | Sampled DAT0 level |
| rd_exp_i | input | 1 | Strobe: a read data block is expected |
| cs_exp_i | input | 1 | Strobe: a write CRC status token is expected |
| busy_exp_i | input | 1 | Strobe: a busy wait follows a response with busy |
| blk_len_i | input | BLK_W | Read block length in bytes (at least 1) |
| tmo_cnt_i | input | TMO_W | Timeout count in SD clock samples |
| clr_we_i | input | 1 | Write strobe for flag clearing |
| clr_i | input | 3 | Clear mask: bit 0 timeout, bit 1 CRC, bit 2 end bit |
| err_tmo_o | output | 1 | Sticky data timeout flag |
| err_crc_o | output | 1 | Sticky data CRC flag |
| err_end_o | output | 1 | Sticky data end-bit flag |

## Verification
The assertions assume that `blk_len_i` and `tmo_cnt_i` stay stable while a phase is running. They also assume that a strobe carries no meaning unless the block is idle. The stimulus therefore sets both values before it pulses a strobe. It always drives each phase to its end, by end bit, busy release or timeout, before it starts the next one. The stimulus drives `sd_en_i` high on only every other clock, so the assertion that a phase holds still while the enable is low is exercised on every sample.

// File: rtl/sd_dat_pkg.sv
package sd_dat_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_WAIT, ST_RD_DATA, ST_RD_CRC, ST_RD_END,
    ST_CS_WAIT, ST_CS_BITS, ST_CS_END, ST_BUSY
  } dat_st_e;

  localparam int unsigned FLG_TMO = 0;
  localparam int unsigned FLG_CRC = 1;
  localparam int unsigned FLG_END = 2;
  localparam int unsigned NUM_FLG = 3;

  localparam logic [2:0] CS_TOKEN_OK = 3'b010;
endpackage

// File: rtl/sd_crc16.sv
module sd_crc16 #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic fb;
  assign fb = crc_o[15] ^ bit_i;

  // feeding the received CRC through the same register leaves zero on a match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= '0;
    else if (clr_i) crc_o <= '0;
    else if (en_i)  crc_o <= {crc_o[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
  end

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(crc_o)); // R12
endmodule

// File: rtl/sd_tmo_timer.sv
module sd_tmo_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMO_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             fire_o
);
  logic [TMO_W-1:0] cnt_q;

  assign fire_o = tick_i && (cnt_q <= TMO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - TMO_W'(1);
  end

  AST_LOAD_NOT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && tick_i)); // R9
  AST_TICK_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q > TMO_W'(1)) |=> (cnt_q == $past(cnt_q) - TMO_W'(1))); // R9
endmodule

// File: rtl/sd_err_flags.sv
module sd_err_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flg_o
);
  for (genvar g = 0; g < N; g++) begin : g_flg
    logic clr;
    assign clr = clr_we_i && clr_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flg_o[g] <= 1'b0;
      else if (set_i[g]) flg_o[g] <= 1'b1;
      else if (clr)      flg_o[g] <= 1'b0;
    end

    AST_FLG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flg_o[g] && !clr) |=> flg_o[g]); // R10
    AST_FLG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr && !set_i[g]) |=> !flg_o[g]); // R10
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flg_o[g]); // R11
  end
endmodule

// File: rtl/sd_dat_err_mon.sv
module sd_dat_err_mon
  import sd_dat_pkg::*;
#(
  parameter int unsigned BLK_W = 12,
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sd_en_i,
  input  logic             dat_i,
  input  logic             rd_exp_i,
  input  logic             cs_exp_i,
  input  logic             busy_exp_i,
  input  logic [BLK_W-1:0] blk_len_i,
  input  logic [TMO_W-1:0] tmo_cnt_i,
  input  logic             clr_we_i,
  input  logic [2:0]       clr_i,
  output logic             err_tmo_o,
  output logic             err_crc_o,
  output logic             err_end_o
);
  localparam int unsigned CNT_W = BLK_W + 3;

  dat_st_e          st_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [2:0]       tok_q;
  logic [15:0]      crc;
  logic             wait_st, evt, tmr_tick, tmr_load, tmr_fire, strobe;
  logic             crc_en;
  logic [NUM_FLG-1:0] flg_set, flg;

  assign strobe   = rd_exp_i || cs_exp_i || busy_exp_i;
  assign wait_st  = (st_q == ST_RD_WAIT) || (st_q == ST_CS_WAIT) || (st_q == ST_BUSY);
  // start bit (0) ends a start wait; a 1 ends busy
  assign evt      = (st_q == ST_BUSY) ? dat_i : !dat_i;
  assign tmr_tick = sd_en_i && wait_st && !evt;
  assign tmr_load = ((st_q == ST_IDLE) && strobe) || ((st_q == ST_CS_END) && sd_en_i);
  assign crc_en   = sd_en_i && ((st_q == ST_RD_DATA) || (st_q == ST_RD_CRC));

  sd_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == ST_IDLE),
    .en_i   (crc_en),
    .bit_i  (dat_i),
    .crc_o  (crc)
  );

  sd_tmo_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmo_cnt_i),
    .tick_i     (tmr_tick),
    .fire_o     (tmr_fire)
  );

  always_comb begin
    flg_set          = '0;
    flg_set[FLG_TMO] = tmr_fire;
    flg_set[FLG_CRC] = sd_en_i && (((st_q == ST_RD_END) && (crc != 16'h0000)) ||
                                   ((st_q == ST_CS_END) && (tok_q != CS_TOKEN_OK)));
    flg_set[FLG_END] = sd_en_i && !dat_i && ((st_q == ST_RD_END) || (st_q == ST_CS_END));
  end

  sd_err_flags #(.N(NUM_FLG)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (flg_set),
    .clr_we_i (clr_we_i),
    .clr_i    (clr_i),
    .flg_o    (flg)
  );

  assign err_tmo_o = flg[FLG_TMO];
  assign err_crc_o = flg[FLG_CRC];
  assign err_end_o = flg[FLG_END];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      tok_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (rd_exp_i)        st_q <= ST_RD_WAIT;
          else if (cs_exp_i)   st_q <= ST_CS_WAIT;
          else if (busy_exp_i) st_q <= ST_BUSY;
        end
        ST_RD_WAIT: if (sd_en_i) begin
          if (!dat_i) begin
            st_q      <= ST_RD_DATA;
            bit_cnt_q <= {blk_len_i, 3'b000} - CNT_W'(1);
          end else if (tmr_fire) st_q <= ST_IDLE;
        end
        ST_RD_DATA: if (sd_en_i) begin
          if (bit_cnt_q == '0) begin
            st_q      <= ST_RD_CRC;
            bit_cnt_q <= CNT_W'(15);
          end else bit_cnt_q <= bit_cnt_q - CNT_W'(1);
        end
        ST_RD_CRC: if (sd_en_i) begin
          if (bit_cnt_q == '0) st_q <= ST_RD_END;
          else                 bit_cnt_q <= bit_cnt_q - CNT_W'(1);
        end
        ST_RD_END: if (sd_en_i) st_q <= ST_IDLE;
        ST_CS_WAIT: if (sd_en_i) begin
          if (!dat_i) begin
            st_q      <= ST_CS_BITS;
            bit_cnt_q <= CNT_W'(2);
          end else if (tmr_fire) st_q <= ST_IDLE;
        end
        ST_CS_BITS: if (sd_en_i) begin
          tok_q <= {tok_q[1:0], dat_i};
          if (bit_cnt_q == '0) st_q <= ST_CS_END;
          else                 bit_cnt_q <= bit_cnt_q - CNT_W'(1);
        end
        ST_CS_END: if (sd_en_i) st_q <= ST_BUSY;
        ST_BUSY: if (sd_en_i) begin
          if (dat_i || tmr_fire) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_FIRE_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_fire |=> (st_q == ST_IDLE)); // R6
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_en_i && st_q != ST_IDLE) |=> $stable(st_q)); // R12
  AST_RD_END_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD_END && sd_en_i) |=> (st_q == ST_IDLE)); // R1
  AST_CS_TO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CS_END && sd_en_i) |=> (st_q == ST_BUSY)); // R8
  AST_ONE_STROBE_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && rd_exp_i) |=> (st_q == ST_RD_WAIT)); // R1
endmodule

// File: tb/sd_dat_err_mon_bench.sv
module sd_dat_err_mon_bench;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        sd_en = 1'b0, dat = 1'b1;
  logic        rd_exp = 1'b0, cs_exp = 1'b0, busy_exp = 1'b0;
  logic [11:0] blk_len = 12'd2;
  logic [15:0] tmo_cnt = 16'd8;
  logic        clr_we = 1'b0;
  logic [2:0]  clr = 3'b000;
  logic        err_tmo, err_crc, err_end;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  sd_dat_err_mon u_sd_dat_err_mon (
    .clk_i(clk), .rst_ni(rst_ni), .sd_en_i(sd_en), .dat_i(dat),
    .rd_exp_i(rd_exp), .cs_exp_i(cs_exp), .busy_exp_i(busy_exp),
    .blk_len_i(blk_len), .tmo_cnt_i(tmo_cnt), .clr_we_i(clr_we), .clr_i(clr),
    .err_tmo_o(err_tmo), .err_crc_o(err_crc), .err_end_o(err_end)
  );

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    logic fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  function automatic logic [7:0] pat(int i, int seed);
    return 8'(i * 37 + seed * 91 + 8'h5A);
  endfunction

  // flags compared as {end, crc, tmo}
  task automatic chk(string req, logic [2:0] exp);
    logic [2:0] got = {err_end, err_crc, err_tmo};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: flags {end,crc,tmo} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic tick(logic b);
    @(negedge clk); dat = b; sd_en = 1'b1;
    @(negedge clk); sd_en = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic clear_all;
    @(negedge clk); clr_we = 1'b1; clr = 3'b111;
    @(negedge clk); clr_we = 1'b0; clr = 3'b000;
  endtask

  // full read block; optional clear mask asserted on the end-bit sample
  task automatic do_read(int nb, int seed, int pre_ones, bit flip, bit endb, logic [2:0] clr_at_end);
    logic [15:0] c = '0;
    logic [7:0]  d;
    blk_len = 12'(nb);
    pulse(rd_exp);
    for (int k = 0; k < pre_ones; k++) tick(1'b1);
    tick(1'b0);
    for (int i = 0; i < nb; i++) begin
      d = pat(i, seed);
      for (int j = 7; j >= 0; j--) begin
        c = crc_step(c, d[j]);
        tick(d[j]);
      end
    end
    if (flip) c[3] = ~c[3];
    for (int j = 15; j >= 0; j--) tick(c[j]);
    @(negedge clk); dat = endb; sd_en = 1'b1;
    if (clr_at_end != 3'b000) begin clr_we = 1'b1; clr = clr_at_end; end
    @(negedge clk); sd_en = 1'b0; clr_we = 1'b0; clr = 3'b000;
  endtask

  task automatic do_token(logic [2:0] tok, bit endb, int busy_lows);
    pulse(cs_exp);
    tick(1'b1);
    tick(1'b0);
    for (int j = 2; j >= 0; j--) tick(tok[j]);
    tick(endb);
    for (int k = 0; k < busy_lows; k++) tick(1'b0);
  endtask

  task automatic t_reset;
    chk("R10 reset state", 3'b000);
  endtask

  task automatic t_read_ok;
    do_read(2, 1, 0, 1'b0, 1'b1, 3'b000);
    chk("R1 R2 R3 clean 2-byte read", 3'b000);
    do_read(5, 7, 3, 1'b0, 1'b1, 3'b000);
    chk("R1 R2 clean 5-byte read with idle lead-in", 3'b000);
    tmo_cnt = 16'd4;
    do_read(1, 3, 3, 1'b0, 1'b1, 3'b000);
    chk("R9 start bit on last allowed sample", 3'b000);
    tmo_cnt = 16'd8;
  endtask

  task automatic t_read_errs;
    do_read(3, 2, 0, 1'b1, 1'b1, 3'b000);
    chk("R2 bad CRC sets crc flag", 3'b010);
    @(negedge clk); clr_we = 1'b1; clr = 3'b000;
    @(negedge clk); clr_we = 1'b0;
    chk("R10 writing zeros leaves flag", 3'b010);
    clear_all;
    chk("R10 write-one clears", 3'b000);
    do_read(2, 4, 0, 1'b0, 1'b0, 3'b000);
    chk("R3 read end bit zero", 3'b100);
    clear_all;
  endtask

  task automatic t_read_timeout;
    tmo_cnt = 16'd3;
    pulse(rd_exp);
    tick(1'b1); tick(1'b1);
    chk("R9 no timeout before count", 3'b000);
    tick(1'b1);
    chk("R6 read start timeout", 3'b001);
    clear_all;
    tmo_cnt = 16'd0;
    pulse(rd_exp);
    tick(1'b1);
    chk("R9 count zero fires on first sample", 3'b001);
    clear_all;
    tmo_cnt = 16'd8;
  endtask

  task automatic t_token;
    do_token(3'b010, 1'b1, 3);
    tick(1'b1);
    chk("R4 R8 good token and released busy", 3'b000);
    do_token(3'b101, 1'b1, 0);
    tick(1'b1);
    chk("R4 bad token sets crc flag", 3'b010);
    clear_all;
    do_token(3'b011, 1'b1, 0);
    tick(1'b1);
    chk("R4 token 011 sets crc flag", 3'b010);
    clear_all;
    do_token(3'b010, 1'b0, 0);
    tick(1'b1);
    chk("R5 token end bit zero", 3'b100);
    clear_all;
  endtask

  task automatic t_token_timeouts;
    tmo_cnt = 16'd4;
    pulse(cs_exp);
    for (int k = 0; k < 4; k++) tick(1'b1);
    chk("R7 CRC status wait timeout", 3'b001);
    clear_all;
    do_token(3'b010, 1'b1, 3);
    chk("R8 busy under limit after token", 3'b000);
    tick(1'b0);
    chk("R8 busy timeout after token", 3'b001);
    clear_all;
    pulse(busy_exp);
    for (int k = 0; k < 3; k++) tick(1'b0);
    tick(1'b1);
    chk("R8 busy strobe released in time", 3'b000);
    pulse(busy_exp);
    for (int k = 0; k < 4; k++) tick(1'b0);
    chk("R8 busy strobe timeout", 3'b001);
    tmo_cnt = 16'd8;
  endtask

  task automatic t_set_wins;
    // timeout flag is set from the previous task
    do_read(2, 9, 0, 1'b1, 1'b0, 3'b111);
    chk("R11 set beats clear, other flag cleared", 3'b110);
    clear_all;
  endtask

  task automatic t_freeze;
    tmo_cnt = 16'd2;
    pulse(rd_exp);
    dat = 1'b1;
    repeat (40) @(negedge clk);
    chk("R12 no count with enable low", 3'b000);
    tick(1'b1);
    chk("R12 one sample counted", 3'b000);
    tick(1'b1);
    chk("R12 second sample fires", 3'b001);
    clear_all;
    tmo_cnt = 16'd8;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_read_ok;
    t_read_errs;
    t_read_timeout;
    t_token;
    t_token_timeouts;
    t_set_wins;
    t_freeze;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule